// File: doc/BRIEF.md
# Transfer Unit Symbol Packer

This block fills fixed-length transfer units on one main-link lane. Each unit spends its first slots on data symbols taken from a ready/valid input. It spends its remaining slots on a fill symbol. The number of data slots per unit can be held constant. It can also be dithered between an upper count and a lower count, in programmable repeat groups, so that the long-run fill rate approaches a fractional target.

A one-cycle line-start pulse captures the configuration. The pulse also restarts the delay counter. The first unit of the line begins only after the programmed number of link clocks. A fallback input replaces the programmed settings with a safe default: a 32-symbol unit, all slots data, no delay, no dithering. If data is missing when a data slot comes up, the block emits fill in that slot and sets a sticky underflow flag.

Top module: `tu_packer`

## Requirements
- R1: While reset is applied and until the first line start, `out_active`, `in_ready`, `out_is_data` and `underflow` are all low.
- R2: After a line start, no unit slot is emitted for (delay + 1) cycles. The delay is taken from `cfg_word0[31:16]`. The first slot appears in the cycle (delay + 1) after the cycle in which the pulse was sampled. Slots then continue on every cycle.
- R3: A unit is `cfg_size_m1 + 1` slots long. Its first V slots are data slots and the rest are fill slots. A fill slot shows `out_sym` equal to the fill symbol (default 0x00).
- R4: `cfg_word0[6:0]` holds the upper data count per unit.
- R5: When `cfg_word1[0]` is 1, dithering is on. The lower data count is in `cfg_word1[7:1]`, the upper repeat count in `cfg_word1[19:16]`, and the lower repeat count in `cfg_word1[23:20]`. Units follow the pattern: upper-count units for the upper repeat count, then lower-count units for the lower repeat count, then repeat.
- R6: When `cfg_word1[0]` is 0, every unit uses the upper data count.
- R7: When `use_fallback` is high at a line start, the line uses 32-slot units with 32 data slots and zero delay, and dithering is off, whatever the two words hold.
- R8: Configuration inputs are captured only at a line start. Changing them in the middle of a line does not alter the slot pattern of that line.
- R9: In a data slot, `in_ready` is high. If `in_valid` is low, the slot carries fill and `out_is_data` is low. `underflow` rises on the next cycle and stays high until reset.
- R10: A line start in the middle of a line aborts that line. The delay starts again, and the next unit begins at slot 0 of the upper-count phase.
- R11: `in_ready` is high exactly in data slots. Accepted symbols appear on `out_sym` in the same cycle and in input order, with `out_is_data` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a new line |
| use_fallback | input | 1 | Selects the default unit settings at line start |
| cfg_size_m1 | input | 6 | Unit length minus one |
| cfg_word0 | input | 32 | Upper data count [6:0], start delay [31:16] |
| cfg_word1 | input | 32 | Dither enable [0], lower count [7:1], upper repeat [19:16], lower repeat [23:20] |
| in_data | input | 8 | Data symbol |
| in_valid | input | 1 | Data symbol available |
| in_ready | output | 1 | Block takes a data symbol this cycle |
| out_sym | output | 8 | Symbol placed on the lane |
| out_active | output | 1 | A unit slot is emitted this cycle |
| out_is_data | output | 1 | Slot carries data rather than fill |
| underflow | output | 1 | Sticky: a data slot found no data |

## Verification
The line-start pulse is registered. Slot k of a line therefore appears in the cycle (delay + 1 + k) after the sampling edge. Data and fill flags are decoded combinationally from the registered slot position, so they change in the same cycle. The underflow flag is registered and appears one cycle after the starved slot. The bench drives inputs and samples outputs on the falling edge. It counts cycles from the edge that sampled line start, and it compares every cycle of a line with a slot model built from the requirements.

// File: rtl/tu_pkg.sv
package tu_pkg;
  localparam int SIZE_W = 6;
  localparam int VCNT_W = SIZE_W + 1;
  localparam int DLY_W  = 16;
  localparam int REP_W  = 4;
  localparam int WORD_W = 32;

  // field positions that the configuration words carry
  localparam int DLY_LSB   = 16;
  localparam int LOV_LSB   = 1;
  localparam int UREP_LSB  = 16;
  localparam int LREP_LSB  = 20;

  localparam int FB_SIZE_M1 = 31;
  localparam int FB_VALID   = 32;

  typedef struct packed {
    logic [SIZE_W-1:0] size_m1;
    logic [VCNT_W-1:0] up_v;
    logic [VCNT_W-1:0] lo_v;
    logic [DLY_W-1:0]  dly;
    logic              dith_en;
    logic [REP_W-1:0]  up_rep;
    logic [REP_W-1:0]  lo_rep;
  } tu_cfg_t;

  typedef enum logic [1:0] {
    LT_IDLE = 2'd0,
    LT_WAIT = 2'd1,
    LT_RUN  = 2'd2
  } lt_state_e;
endpackage

// File: rtl/tu_cfg_snap.sv
module tu_cfg_snap
  import tu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              use_fallback,
  input  logic [SIZE_W-1:0] size_m1_in,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  output tu_cfg_t           cfg_q
);
  tu_cfg_t cfg_d;
  logic    unused_bits;

  assign unused_bits = ^{word0[DLY_LSB-1:VCNT_W], word1[UREP_LSB-1:LOV_LSB+VCNT_W],
                         word1[WORD_W-1:LREP_LSB+REP_W]};

  always_comb begin
    if (use_fallback) begin
      cfg_d.size_m1 = SIZE_W'(FB_SIZE_M1);
      cfg_d.up_v    = VCNT_W'(FB_VALID);
      cfg_d.lo_v    = VCNT_W'(FB_VALID);
      cfg_d.dly     = '0;
      cfg_d.dith_en = 1'b0;
      cfg_d.up_rep  = REP_W'(1);
      cfg_d.lo_rep  = REP_W'(1);
    end else begin
      cfg_d.size_m1 = size_m1_in;
      cfg_d.up_v    = word0[VCNT_W-1:0];
      cfg_d.lo_v    = word1[LOV_LSB +: VCNT_W];
      cfg_d.dly     = word0[DLY_LSB +: DLY_W];
      cfg_d.dith_en = word1[0];
      cfg_d.up_rep  = word1[UREP_LSB +: REP_W];
      cfg_d.lo_rep  = word1[LREP_LSB +: REP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (line_start) cfg_q <= cfg_d;
  end

  // R8: the captured settings move only on a line start
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> $stable(cfg_q));
endmodule

// File: rtl/tu_line_timer.sv
module tu_line_timer
  import tu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [DLY_W-1:0] dly,
  output logic             run
);
  lt_state_e        st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (line_start) begin
      st_d  = LT_WAIT;
      cnt_d = '0;
    end else if (st_q == LT_WAIT) begin
      if (cnt_q == dly) st_d = LT_RUN;
      else              cnt_d = cnt_q + DLY_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LT_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign run = (st_q == LT_RUN);

  // R2: the wait counter never passes the programmed delay
  a_r2_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LT_WAIT) |-> (cnt_q <= dly));
  // R2: running only begins from a wait that reached the delay
  a_r2_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LT_WAIT && cnt_q != dly && !line_start) |=> (st_q == LT_WAIT));
endmodule

// File: rtl/tu_unit_seq.sv
module tu_unit_seq
  import tu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              run,
  input  tu_cfg_t           cfg,
  output logic              slot_data
);
  logic [SIZE_W-1:0] pos_q, pos_d;
  logic              upper_q, upper_d;
  logic [REP_W-1:0]  rep_q, rep_d;
  logic [VCNT_W-1:0] cur_v;
  logic              unit_end;

  assign unit_end = run && (pos_q == cfg.size_m1);
  assign cur_v    = (cfg.dith_en && !upper_q) ? cfg.lo_v : cfg.up_v;

  always_comb begin
    pos_d   = pos_q;
    upper_d = upper_q;
    rep_d   = rep_q;
    if (line_start) begin
      pos_d   = '0;
      upper_d = 1'b1;
      rep_d   = REP_W'(1);
    end else if (unit_end) begin
      pos_d = '0;
      if (cfg.dith_en) begin
        if (rep_q == (upper_q ? cfg.up_rep : cfg.lo_rep)) begin
          upper_d = !upper_q;
          rep_d   = REP_W'(1);
        end else begin
          rep_d   = rep_q + REP_W'(1);
        end
      end
    end else if (run) begin
      pos_d = pos_q + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      upper_q <= 1'b1;
      rep_q   <= REP_W'(1);
    end else begin
      pos_q   <= pos_d;
      upper_q <= upper_d;
      rep_q   <= rep_d;
    end
  end

  assign slot_data = run && ({1'b0, pos_q} < cur_v);

  // R3: slot position stays inside the unit
  a_r3_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= cfg.size_m1);
  // R5: the dither phase changes only at a unit boundary or a line start
  a_r5_phase_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && !unit_end) |=> $stable(upper_q));
  // R10: a line start returns the sequence to the upper phase, slot 0
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (upper_q && pos_q == '0));
endmodule

// File: rtl/tu_packer.sv
module tu_packer
  import tu_pkg::*;
#(
  parameter int         SYM_W    = 8,
  parameter logic [7:0] FILL_SYM = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              use_fallback,
  input  logic [SIZE_W-1:0] cfg_size_m1,
  input  logic [WORD_W-1:0] cfg_word0,
  input  logic [WORD_W-1:0] cfg_word1,
  input  logic [SYM_W-1:0]  in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [SYM_W-1:0]  out_sym,
  output logic              out_active,
  output logic              out_is_data,
  output logic              underflow
);
  localparam logic [SYM_W-1:0] FILL = SYM_W'(FILL_SYM);

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  tu_cfg_t    cfg_q;
  logic       run;
  logic       slot_data;
  logic       uflow_d, uflow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  tu_cfg_snap u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .line_start(line_start),
    .use_fallback(use_fallback), .size_m1_in(cfg_size_m1),
    .word0(cfg_word0), .word1(cfg_word1), .cfg_q(cfg_q)
  );

  tu_line_timer u_timer (
    .clk(clk), .rst_n(rst_sync_n), .line_start(line_start),
    .dly(cfg_q.dly), .run(run)
  );

  tu_unit_seq u_seq (
    .clk(clk), .rst_n(rst_sync_n), .line_start(line_start),
    .run(run), .cfg(cfg_q), .slot_data(slot_data)
  );

  assign in_ready    = slot_data;
  assign out_active  = run;
  assign out_is_data = slot_data && in_valid;
  assign out_sym     = out_is_data ? in_data : FILL;

  always_comb begin
    uflow_d = uflow_q;
    if (slot_data && !in_valid) uflow_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) uflow_q <= 1'b0;
    else             uflow_q <= uflow_d;
  end
  assign underflow = uflow_q;

  // R9: underflow never clears outside reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    underflow |=> underflow);
  // R9: a starved data slot is reported on the next cycle
  a_r9_report: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_ready && !in_valid) |=> underflow);
  // R3: a slot without data shows the fill symbol
  a_r3_fill_sym: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_active && !out_is_data) |-> (out_sym == FILL));
  // R11: data is taken only while a slot is emitted
  a_r11_ready_in_slot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_ready |-> out_active);
endmodule

// File: tb/test_tu_packer.sv
module test_tu_packer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_start;
  logic        use_fallback;
  logic [5:0]  cfg_size_m1;
  logic [31:0] cfg_word0, cfg_word1;
  logic [7:0]  in_data;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  out_sym;
  logic        out_active, out_is_data, underflow;

  int checks = 0;
  int fails  = 0;
  int dcount = 0;

  always #5 clk = ~clk;

  tu_packer i_tu_packer (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .use_fallback(use_fallback),
    .cfg_size_m1(cfg_size_m1), .cfg_word0(cfg_word0), .cfg_word1(cfg_word1),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_sym(out_sym), .out_active(out_active), .out_is_data(out_is_data),
    .underflow(underflow)
  );

  typedef struct packed {
    int size; int up; int lo; int dly; int dith; int ur; int lr; int fb; int win; int lat;
  } vec_t;

  // stimulus: size, upper, lower, delay, dither, urep, lrep, fallback, window; expected: latency
  localparam vec_t TBL [6] = '{
    '{32, 20,  0,  0, 0,  1,  1, 0,  300,  1},   // R3 R4 R6
    '{64, 40, 39,  5, 1,  2,  3, 0,  400,  6},   // R5 R10 (restarts previous line)
    '{40, 39, 38,  3, 1,  1,  1, 0,  300,  4},   // R5 alternate every unit
    '{48, 30, 29, 10, 1, 15, 15, 0, 1600, 11},   // R5 longest groups
    '{11, 50, 49, 50, 1,  3,  3, 1,  300,  1},   // R7 fallback overrides words
    '{33,  1,  0,  2, 1,  3,  2, 0,  400,  3}    // R5 minimal counts
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_cfg(input int size, up, lo, dly, dith, ur, lr, fb);
    use_fallback = fb[0];
    cfg_size_m1  = 6'(size - 1);
    cfg_word0    = {dly[15:0], 9'd0, up[6:0]};
    cfg_word1    = {8'd0, lr[3:0], ur[3:0], 8'd0, lo[6:0], dith[0]};
  endtask

  // model: expected activity and data flag for sample k after the line-start edge
  function automatic void model(input int k, size, up, lo, dly, dith, ur, lr,
                                output bit act, output bit dat);
    int s, u, p, v;
    if (k < dly + 1) begin act = 0; dat = 0; return; end
    s = k - dly - 1; u = s / size; p = s % size; v = up;
    if (dith != 0 && (u % (ur + lr)) >= ur) v = lo;
    act = 1; dat = (p < v);
  endfunction

  // one line: starts it, walks win cycles; chg_at >= 0 scrambles config there (R8)
  task automatic run_line(input vec_t t, input int chg_at, input string tag);
    int  s_size, s_up, s_lo, s_dly, s_dith;
    int  bad, first_act, fk, fa, fe;
    bit  ea, ed;
    if (t.fb != 0) begin s_size = 32; s_up = 32; s_lo = 32; s_dly = 0; s_dith = 0; end
    else begin s_size = t.size; s_up = t.up; s_lo = t.lo; s_dly = t.dly; s_dith = t.dith; end
    drive_cfg(t.size, t.up, t.lo, t.dly, t.dith, t.ur, t.lr, t.fb);
    dcount = 0; in_data = 8'd0; in_valid = 1'b1;
    line_start = 1'b1;
    @(posedge clk); @(negedge clk);
    line_start = 1'b0;
    bad = 0; first_act = -1; fk = 0; fa = 0; fe = 0;
    for (int k = 0; k < t.win; k++) begin
      if (k == chg_at) drive_cfg(17, 3, 2, 7, 1 - s_dith, 2, 2, 0);
      model(k, s_size, s_up, s_lo, s_dly, s_dith, t.ur, t.lr, ea, ed);
      if (out_active && first_act < 0) first_act = k;
      if (out_active !== ea || out_is_data !== ed || in_ready !== ed ||
          (ed && out_sym !== 8'(dcount)) || (!ed && out_sym !== 8'h00)) begin
        if (bad == 0) begin fk = k; fa = {out_active, out_is_data, in_ready}; fe = {ea, ed, ed}; end
        bad++;
      end
      if (ed) begin dcount++; in_data = 8'(dcount); end
      @(negedge clk);
    end
    check(first_act == t.lat, tag, "first slot latency", first_act, t.lat);
    check(bad == 0, tag, $sformatf("slot pattern (first at k=%0d, flags)", fk), fa, fe);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    vec_t t;
    rst_n = 1'b0; line_start = 1'b0; in_valid = 1'b0; in_data = 8'd0;
    drive_cfg(32, 32, 31, 0, 0, 1, 1, 0);
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check(!out_active && !in_ready && !out_is_data && !underflow, "R1", "outputs in reset",
          {out_active, in_ready, out_is_data, underflow}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: quiet after reset before any line start
    check(!out_active && !in_ready && !underflow, "R1", "outputs before line start",
          {out_active, in_ready, underflow}, 0);

    // table walk (each line after the first also restarts a running line: R10)
    for (int i = 0; i < 6; i++) run_line(TBL[i], -1, $sformatf("R2/R3/R5 vec%0d", i));

    // R8: mid-line change of every config input has no effect
    t = '{48, 30, 29, 4, 1, 2, 2, 0, 400, 5};
    run_line(t, 60, "R8");
    // R10: restart in the middle of a unit gives a fresh delay and upper phase
    t = '{40, 25, 24, 6, 1, 1, 2, 0, 300, 7};
    run_line(t, -1, "R10");

    // R2: long delay measured by counting
    t = '{32, 16, 15, 1500, 0, 1, 1, 0, 1600, 1501};
    run_line(t, -1, "R2 long delay");

    // R9: starved data slot emits fill, flag sticks
    drive_cfg(32, 32, 31, 0, 0, 1, 1, 0);
    in_valid = 1'b1; line_start = 1'b1;
    @(posedge clk); @(negedge clk);
    line_start = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_active && in_ready && !out_is_data && out_sym == 8'h00, "R9", "starved slot flags",
          {out_active, in_ready, out_is_data}, 3'b110);
    check(!underflow, "R9", "underflow before report edge", underflow, 0);
    @(negedge clk);
    check(underflow, "R9", "underflow raised", underflow, 1);
    in_valid = 1'b1; line_start = 1'b1;
    @(posedge clk); @(negedge clk);
    line_start = 1'b0;
    repeat (20) @(negedge clk);
    check(underflow, "R9", "underflow sticky across line", underflow, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule